// File: doc/BRIEF.md
# Lit-Pixel Coordinate Frame Emitter

This block scans a monochrome image stored as a packed bitmap in a byte-wide display memory. For each lit pixel it reports one coordinate word. A refresh starts with a one-cycle start pulse. The block then raises a frame flag and walks the image one pixel row at a time, from the top row down. Within each row it reads one byte for every column cell. From that byte it uses the low bits, as many as the font width, and emits the X/Y position of every bit that is set. After the last cell it lowers the frame flag and pulses a done output.

The geometry comes from four inputs: a column-count select, a character-line select with eight pixel rows per line, a font-width select, and the base address of the bitmap in memory. All four are sampled when a refresh is accepted. A downstream consumer that draws or compares the picture only has to watch the frame flag and the coordinate strobe. Unlit pixels cost it nothing.

Top module: `lit_pixel_streamer`

## Requirements
- R1: A start pulse seen while idle makes `frame_o` read 1 in the next cycle. No coordinate strobe appears while `frame_o` is 0.
- R2: Exactly one coordinate word is emitted for every set bit that is used, and none for a cleared bit. Words come in raster order: rows top to bottom, then X ascending within a row.
- R3: A coordinate word carries X in bits 31:16 and Y (the pixel row) in bits 15:0.
- R4: `cols_sel_i` codes 0, 1, 2, 3 select 32, 40, 64, 80 column cells per row.
- R5: `lines_sel_i` code n selects 2*(n+1) character lines of 8 pixel rows each, so Y runs from 0 to 16*(n+1)-1.
- R6: `font_sel_i` code f selects a cell width w = 5+f. Of each byte, bits w-1 down to 0 are used, most significant first, and give X = column*w + 0 .. w-1. Bits above w-1 have no effect on the output.
- R7: The byte for pixel row y and column c is read from address base + y*columns + c, modulo 2^16. `ram_rd_en_o` is high for one cycle per byte, and `ram_data_i` is taken in the following cycle.
- R8: A start pulse that arrives while a refresh is running is ignored. It neither restarts the scan nor queues a second one.
- R9: `done_o` is high for exactly the one cycle in which `frame_o` has just fallen.
- R10: Changes to the geometry inputs and the base address during a refresh have no effect on that refresh.
- R11: `coord_vld_o` is high for one clock per lit pixel, with the matching word on `coord_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Refresh request pulse |
| cols_sel_i | input | 2 | Column-count select |
| lines_sel_i | input | 3 | Character-line count select |
| font_sel_i | input | 2 | Cell width select |
| base_i | input | 16 | Bitmap base address |
| ram_rd_en_o | output | 1 | Display memory read enable |
| ram_addr_o | output | 16 | Display memory read address |
| ram_data_i | input | 8 | Read data, valid one cycle after the read |
| frame_o | output | 1 | High for the duration of a refresh |
| coord_vld_o | output | 1 | Coordinate strobe |
| coord_o | output | 32 | X in 31:16, Y in 15:0 |
| done_o | output | 1 | One-cycle pulse as the frame flag drops |

## Verification
The hardest state to reach from the ports is a second start request that lands in the middle of a scan while the geometry and base inputs are also being changed. Any design that restarts, re-reads its configuration or remembers the request shows it only as a corrupted coordinate stream or as a second frame. The bench drives that case on purpose about thirty cycles into a wide refresh: it pulses start and inverts every configuration input. It then checks that the stream still matches the originally planned picture and that the frame flag stays low afterwards. Address wrap past the top of memory is reached with a base close to 0xFFFF. An all-ones pattern with a narrow cell checks that the bits above the cell width are ignored.

// File: rtl/lps_pkg.sv
package lps_pkg;
    localparam int COL_W  = 7;   // column index, up to 80 cells
    localparam int PROW_W = 7;   // pixel-row index, up to 128 rows
    localparam int FW_W   = 4;   // cell width value 5..8
    localparam int BYTE_W = 8;   // display memory data width

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_READ  = 3'd1,
        S_TAKE  = 3'd2,
        S_SHIFT = 3'd3,
        S_CLOSE = 3'd4
    } scan_st_e;
endpackage

// File: rtl/lps_geom.sv
module lps_geom
    import lps_pkg::*;
(
    input  logic [1:0]        cols_sel_i,
    input  logic [2:0]        lines_sel_i,
    input  logic [1:0]        font_sel_i,
    output logic [COL_W-1:0]  ncols_o,
    output logic [PROW_W:0]   nprows_o,
    output logic [FW_W-1:0]   fw_o
);
    logic [3:0] lines_n;

    always_comb begin
        case (cols_sel_i)
            2'd0:    ncols_o = COL_W'(32);
            2'd1:    ncols_o = COL_W'(40);
            2'd2:    ncols_o = COL_W'(64);
            default: ncols_o = COL_W'(80);
        endcase
        // two character lines per code step, eight pixel rows each
        lines_n  = {1'b0, lines_sel_i} + 4'd1;
        nprows_o = {lines_n, 4'b0000};
        fw_o     = FW_W'(5) + {2'b00, font_sel_i};
    end
endmodule

// File: rtl/lps_scan.sv
module lps_scan
    import lps_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int HALF_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [COL_W-1:0]     ncols_i,
    input  logic [PROW_W:0]      nprows_i,
    input  logic [FW_W-1:0]      fw_i,
    input  logic [ADDR_W-1:0]    base_i,
    output logic                 rd_en_o,
    output logic [ADDR_W-1:0]    addr_o,
    input  logic [BYTE_W-1:0]    data_i,
    output logic                 frame_o,
    output logic                 vld_o,
    output logic [2*HALF_W-1:0]  coord_o,
    output logic                 done_o
);
    typedef struct packed {
        scan_st_e             st;
        logic                 frame;
        logic                 done;
        logic                 vld;
        logic                 rd_en;
        logic [ADDR_W-1:0]    addr;
        logic [ADDR_W-1:0]    row_base;
        logic [2*HALF_W-1:0]  coord;
        logic [COL_W-1:0]     col;
        logic [COL_W-1:0]     ncols;
        logic [PROW_W-1:0]    row;
        logic [PROW_W:0]      nprows;
        logic [FW_W-1:0]      fw;
        logic [FW_W-1:0]      xk;
        logic [HALF_W-1:0]    xcell;
        logic [BYTE_W-1:0]    bits;
    } scan_t;

    scan_t scan_q, scan_d;

    logic              step;
    logic              col_last;
    logic              row_last;
    logic [BYTE_W-1:0] masked;
    logic [BYTE_W-1:0] cell_mask;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        scan_d    = scan_q;
        scan_d.vld   = 1'b0;
        scan_d.done  = 1'b0;
        scan_d.rd_en = 1'b0;
        step      = 1'b0;
        cell_mask = {BYTE_W{1'b1}} >> (FW_W'(BYTE_W) - scan_q.fw);
        masked    = data_i & cell_mask;
        shifted   = scan_q.bits << 1;
        col_last  = (scan_q.col == scan_q.ncols - COL_W'(1));
        row_last  = ({1'b0, scan_q.row} == scan_q.nprows - (PROW_W+1)'(1));

        case (scan_q.st)
            S_IDLE: begin
                if (start_i) begin
                    scan_d.ncols    = ncols_i;
                    scan_d.nprows   = nprows_i;
                    scan_d.fw       = fw_i;
                    scan_d.row_base = base_i;
                    scan_d.col      = '0;
                    scan_d.row      = '0;
                    scan_d.xcell    = '0;
                    scan_d.frame    = 1'b1;
                    scan_d.rd_en    = 1'b1;
                    scan_d.addr     = base_i;
                    scan_d.st       = S_READ;
                end
            end
            S_READ: begin
                scan_d.st = S_TAKE;
            end
            S_TAKE: begin
                if (masked == '0) begin
                    step = 1'b1;
                end else begin
                    scan_d.bits = masked << (FW_W'(BYTE_W) - scan_q.fw);
                    scan_d.xk   = '0;
                    scan_d.st   = S_SHIFT;
                end
            end
            S_SHIFT: begin
                scan_d.vld = scan_q.bits[BYTE_W-1];
                if (scan_q.bits[BYTE_W-1]) begin
                    scan_d.coord = {scan_q.xcell + HALF_W'(scan_q.xk),
                                    HALF_W'(scan_q.row)};
                end
                scan_d.bits = shifted;
                scan_d.xk   = scan_q.xk + FW_W'(1);
                if (shifted == '0) begin
                    step = 1'b1;
                end
            end
            S_CLOSE: begin
                scan_d.frame = 1'b0;
                scan_d.done  = 1'b1;
                scan_d.st    = S_IDLE;
            end
            default: begin
                scan_d.st = S_IDLE;
            end
        endcase

        // advance to the next cell, row, or end of frame
        if (step) begin
            if (col_last) begin
                scan_d.col   = '0;
                scan_d.xcell = '0;
                if (row_last) begin
                    scan_d.st = S_CLOSE;
                end else begin
                    scan_d.row      = scan_q.row + PROW_W'(1);
                    scan_d.row_base = scan_q.row_base + ADDR_W'(scan_q.ncols);
                    scan_d.addr     = scan_q.row_base + ADDR_W'(scan_q.ncols);
                    scan_d.rd_en    = 1'b1;
                    scan_d.st       = S_READ;
                end
            end else begin
                scan_d.col   = scan_q.col + COL_W'(1);
                scan_d.xcell = scan_q.xcell + HALF_W'(scan_q.fw);
                scan_d.addr  = scan_q.row_base + ADDR_W'(scan_q.col) + ADDR_W'(1);
                scan_d.rd_en = 1'b1;
                scan_d.st    = S_READ;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_q <= '0;
        end else begin
            scan_q <= scan_d;
        end
    end

    assign rd_en_o = scan_q.rd_en;
    assign addr_o  = scan_q.addr;
    assign frame_o = scan_q.frame;
    assign vld_o   = scan_q.vld;
    assign coord_o = scan_q.coord;
    assign done_o  = scan_q.done;
endmodule

// File: rtl/lit_pixel_streamer.sv
module lit_pixel_streamer
    import lps_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int HALF_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [1:0]           cols_sel_i,
    input  logic [2:0]           lines_sel_i,
    input  logic [1:0]           font_sel_i,
    input  logic [ADDR_W-1:0]    base_i,
    output logic                 ram_rd_en_o,
    output logic [ADDR_W-1:0]    ram_addr_o,
    input  logic [BYTE_W-1:0]    ram_data_i,
    output logic                 frame_o,
    output logic                 coord_vld_o,
    output logic [2*HALF_W-1:0]  coord_o,
    output logic                 done_o
);
    logic [COL_W-1:0] ncols;
    logic [PROW_W:0]  nprows;
    logic [FW_W-1:0]  fw;

    lps_geom u_geom (
        .cols_sel_i  (cols_sel_i),
        .lines_sel_i (lines_sel_i),
        .font_sel_i  (font_sel_i),
        .ncols_o     (ncols),
        .nprows_o    (nprows),
        .fw_o        (fw)
    );

    lps_scan #(
        .ADDR_W (ADDR_W),
        .HALF_W (HALF_W)
    ) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .ncols_i  (ncols),
        .nprows_i (nprows),
        .fw_i     (fw),
        .base_i   (base_i),
        .rd_en_o  (ram_rd_en_o),
        .addr_o   (ram_addr_o),
        .data_i   (ram_data_i),
        .frame_o  (frame_o),
        .vld_o    (coord_vld_o),
        .coord_o  (coord_o),
        .done_o   (done_o)
    );
endmodule

// File: rtl/lps_chk.sv
module lps_chk #(
    parameter int HALF_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                frame_o,
    input logic                coord_vld_o,
    input logic [2*HALF_W-1:0] coord_o,
    input logic                done_o,
    input logic                ram_rd_en_o
);
    p_coord_in_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        coord_vld_o |-> frame_o);

    p_rise_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_o) |-> $past(start_i));

    p_read_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en_o |-> frame_o);

    p_read_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en_o |=> !ram_rd_en_o);

    p_done_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_o) |-> done_o);

    p_done_only_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $fell(frame_o));

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_o && start_i) |=> (frame_o || done_o));

    p_y_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        coord_vld_o |-> (coord_o[HALF_W-1:0] < HALF_W'(128)));

    p_x_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        coord_vld_o |-> (coord_o[2*HALF_W-1:HALF_W] < HALF_W'(640)));
endmodule

bind lit_pixel_streamer lps_chk #(.HALF_W(HALF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .frame_o     (frame_o),
    .coord_vld_o (coord_vld_o),
    .coord_o     (coord_o),
    .done_o      (done_o),
    .ram_rd_en_o (ram_rd_en_o)
);

// File: tb/sim_lit_pixel_streamer.sv
module sim_lit_pixel_streamer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cols_sel = '0;
    logic [2:0]  lines_sel = '0;
    logic [1:0]  font_sel = '0;
    logic [15:0] base = '0;
    logic        rd_en;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data = '0;
    logic        frame;
    logic        cvld;
    logic [31:0] coord;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;
    int n_vld = 0;
    logic [1:0]  pmode = '0;
    logic [7:0]  pseed = '0;
    logic [31:0] exp_q[$];
    logic [15:0] addr_q[$];
    logic [31:0] mon_e;
    logic [15:0] mon_a;

    always #5 clk = ~clk;

    lit_pixel_streamer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .cols_sel_i  (cols_sel),
        .lines_sel_i (lines_sel),
        .font_sel_i  (font_sel),
        .base_i      (base),
        .ram_rd_en_o (rd_en),
        .ram_addr_o  (rd_addr),
        .ram_data_i  (rd_data),
        .frame_o     (frame),
        .coord_vld_o (cvld),
        .coord_o     (coord),
        .done_o      (done)
    );

    function automatic logic [7:0] patf(input logic [15:0] a);
        logic [15:0] h;
        h = a * 16'h2F1D ^ {pseed, 8'h5A};
        h = h ^ (h >> 7);
        h = h ^ (h << 3);
        case (pmode)
            2'd0:    return 8'h00;
            2'd1:    return 8'hFF;
            2'd2:    return h[7:0];
            default: return h[7:0] & h[15:8];
        endcase
    endfunction

    // display memory model: one cycle read latency
    always @(posedge clk) begin
        if (rd_en) rd_data <= patf(rd_addr);
    end

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // monitor: compare results against the scoreboard queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (cvld) begin
                n_vld++;
                check(frame == 1'b1, "R1 strobe outside frame", 32'(frame), 32'd1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected coordinate", coord, 32'hFFFF_FFFF);
                end else begin
                    mon_e = exp_q.pop_front();
                    check(coord == mon_e, "R2 R3 coordinate order/value", coord, mon_e);
                end
            end
            if (rd_en) begin
                if (addr_q.size() == 0) begin
                    check(1'b0, "R7 unexpected read", 32'(rd_addr), 32'hFFFF);
                end else begin
                    mon_a = addr_q.pop_front();
                    check(rd_addr == mon_a, "R7 read address", 32'(rd_addr), 32'(mon_a));
                end
            end
        end
    end

    // driver: compute expected reads and lit coordinates
    task automatic plan_frame(input int cs, input int ls, input int fs,
                              input logic [15:0] b);
        int ncols;
        int nrows;
        int fw;
        logic [15:0] a;
        logic [7:0]  v;
        ncols = (cs == 0) ? 32 : (cs == 1) ? 40 : (cs == 2) ? 64 : 80;
        nrows = (ls + 1) * 16;
        fw    = 5 + fs;
        for (int y = 0; y < nrows; y++) begin
            for (int c = 0; c < ncols; c++) begin
                a = 16'(int'(b) + y * ncols + c);
                addr_q.push_back(a);
                v = patf(a);
                for (int k = 0; k < fw; k++) begin
                    if (v[fw-1-k]) exp_q.push_back({16'(c * fw + k), 16'(y)});
                end
            end
        end
    endtask

    task automatic run_frame(input int cs, input int ls, input int fs,
                             input logic [15:0] b, input logic [1:0] mode,
                             input logic [7:0] seed, input bit disturb);
        int n_exp;
        int v0;
        pmode     = mode;
        pseed     = seed;
        cols_sel  = 2'(cs);
        lines_sel = 3'(ls);
        font_sel  = 2'(fs);
        base      = b;
        plan_frame(cs, ls, fs, b);
        n_exp = exp_q.size();
        v0    = n_vld;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(frame == 1'b1, "R1 frame rises after start", 32'(frame), 32'd1);
        check(cvld == 1'b0, "R1 no coordinate with first frame cycle", 32'(cvld), 32'd0);
        if (disturb) begin
            repeat (30) @(negedge clk);
            start     = 1'b1;
            cols_sel  = ~cols_sel;
            lines_sel = ~lines_sel;
            font_sel  = ~font_sel;
            base      = ~base;
            @(negedge clk) start = 1'b0;
            check(frame == 1'b1, "R8 frame continues after mid-scan start", 32'(frame), 32'd1);
        end
        while (!done) @(negedge clk);
        check(frame == 1'b0, "R9 frame low with done", 32'(frame), 32'd0);
        check(exp_q.size() == 0, "R2 all lit pixels emitted", 32'(exp_q.size()), 32'd0);
        check(addr_q.size() == 0, "R7 all bytes read", 32'(addr_q.size()), 32'd0);
        check((n_vld - v0) == n_exp, "R11 R4 R5 R6 one strobe per lit pixel",
              32'(n_vld - v0), 32'(n_exp));
        if (disturb) begin
            check((n_vld - v0) == n_exp, "R10 config change mid-frame ignored",
                  32'(n_vld - v0), 32'(n_exp));
        end
        @(negedge clk);
        check(done == 1'b0, "R9 done lasts one cycle", 32'(done), 32'd0);
        if (disturb) begin
            repeat (4) begin
                @(negedge clk);
                check(frame == 1'b0, "R8 ignored start not queued", 32'(frame), 32'd0);
            end
        end
        exp_q.delete();
        addr_q.delete();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(frame == 1'b0, "R1 reset frame low", 32'(frame), 32'd0);
        check(cvld == 1'b0, "R11 reset strobe low", 32'(cvld), 32'd0);
        check(done == 1'b0, "R9 reset done low", 32'(done), 32'd0);
        check(rd_en == 1'b0, "R7 reset no read", 32'(rd_en), 32'd0);

        // 32 cols, 16 rows, width 8, scattered pattern
        run_frame(0, 0, 3, 16'h0100, 2'd2, 8'h11, 1'b0);
        // 40 cols, 32 rows, width 5, all ones, address wrap (R6 upper bits ignored)
        run_frame(1, 1, 0, 16'hFFF0, 2'd1, 8'h00, 1'b0);
        // 64 cols, width 6, empty image: no coordinates
        run_frame(2, 0, 1, 16'h2000, 2'd0, 8'h00, 1'b0);
        // 80 cols, width 7, disturbed mid-frame (R8, R10)
        run_frame(3, 0, 2, 16'h4321, 2'd2, 8'h7C, 1'b1);
        // 32 cols, 128 rows, width 8, sparse pattern
        run_frame(0, 7, 3, 16'h8000, 2'd3, 8'hA5, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule